// File: doc/BRIEF.md
# Safe Rectifier Cell-Mode Assigner for a Two-Cell Back-to-Back Stack

This block serves the line-side half of a two-cell cascaded H-bridge stack whose DC links are shared directly with a load-side stack. There is no isolation stage between the two stacks. Once per rectifier switching period the block receives a strobe. On that strobe it reads the signed modulation reference, the direction of power exchange and the two link voltages. It then gives one cell a fixed level and the other cell a pulsed level. The pulsed cell alternates between an active level and zero. The split is chosen so that the weaker capacitor gains charge.

The modes must still be turned into switch pairs. A zero level can be built as the top pair or as the bottom pair, and the block tries these in a fixed order. It joins each candidate with the load-side pair codes held for the same period. A candidate is accepted only if it avoids every interconnect pattern that would short a capacitor or place the two capacitors in opposition. It is also rejected if it turns on both switches of one leg. The first safe candidate is registered at the period boundary. If none is safe, every gate is held off and a fault flag is raised.

The input side is a plain per-period strobe with no back-pressure: all inputs are sampled on the strobe edge. Results appear one clock later and are held until the next strobe. The carrier comparison that uses the duty output, and the gate drivers, sit outside this block.

Top module: `hb_cell_mode_assigner`

## Requirements
- R1: After reset all eight gate outputs are 0, the fault flag is 0, the pulsed-cell select is 0 and the duty output is 0.
- R2: Outputs change only on the clock edge where `period_strobe` is 1, using the inputs present at that edge. They are visible from the next clock on and are held while the strobe stays 0.
- R3: The reference is signed two's complement with FRAC_W fraction bits, so 1.0 is 2^FRAC_W. If |ref| < 1.0, the fixed cell sits at zero and the pulsed cell alternates between the reference-sign level and zero. If |ref| >= 1.0, the fixed cell holds the reference-sign level and the pulsed cell alternates between that level and zero. A reference of 0 counts as positive.
- R4: Charging holds when the reference sign equals the current sign. The weaker cell is the lower one if `vdc_upper > vdc_lower`, and the upper one otherwise (ties go to the upper cell). When charging: below 1.0 the pulsed cell is the weaker cell, and at or above 1.0 the fixed cell is the weaker cell. When not charging, each of these choices is reversed. `pwm_cell` is 0 when the upper cell is pulsed and 1 when the lower cell is pulsed.
- R5: With `sign_from_volt` at 1, `volt_pos` is used as the current sign. With it at 0, `cur_pos` is used.
- R6: Pair codes and gate nibbles: bit k-1 drives switch k of a cell. The code values are 0 for top zero (1,2) = 4'b0011, 1 for positive (1,4) = 4'b1001, 2 for negative (2,3) = 4'b0110, and 3 for bottom zero (3,4) = 4'b1100. The `_on` nibble applies while the carrier pulse is high and the `_off` nibble while it is low. For the fixed cell the two nibbles are equal.
- R7: Interconnect bits are formed as follows. Bits 1 and 3 come from the upper rectifier cell's switches 2 and 4. Bits 2 and 4 come from the lower rectifier cell's switches 1 and 3. Bits 5 and 7 come from the upper load-side cell's switches 2 and 4. Bits 6 and 8 come from the lower load-side cell's switches 1 and 3. A pattern is unsafe if it contains any of these groups: {1,4,5,6}, {1,4,7,8}, {2,3,5,6}, {2,3,7,8}, {1,2,5,8}, {1,2,6,7}, {3,4,5,8}, {3,4,6,7}, {1,4,6,7}, {2,3,5,8}. It is also unsafe if it contains any of the leg pairs {1,3}, {2,4}, {5,7}, {6,8}. Both the pulse-high and pulse-low patterns must be safe.
- R8: Realizations are tried in this order: fixed-cell zero as top pair then bottom pair (outer), and pulsed-cell zero as top pair then bottom pair (inner). The first candidate that is safe is taken.
- R9: If no candidate is safe, `no_safe_fault` is 1 and all gate outputs are 0 for that period. A later safe period clears the flag.
- R10: `pwm_duty` is |ref| below 1.0, and |ref| - 1.0 at or above it, saturated to 2^FRAC_W - 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| period_strobe | input | 1 | Start of a rectifier switching period; samples all inputs |
| ref_lvl | input | REF_W | Signed modulation reference in link-voltage units |
| cur_pos | input | 1 | Input current sign, 1 = positive |
| volt_pos | input | 1 | Input voltage sign, 1 = positive |
| sign_from_volt | input | 1 | Use voltage sign in place of current sign |
| vdc_upper | input | VDC_W | Upper link voltage |
| vdc_lower | input | VDC_W | Lower link voltage |
| inv_upper_code | input | 2 | Load-side upper cell pair code |
| inv_lower_code | input | 2 | Load-side lower cell pair code |
| rect_upper_gate_on | output | 4 | Upper cell gates, pulse high |
| rect_upper_gate_off | output | 4 | Upper cell gates, pulse low |
| rect_lower_gate_on | output | 4 | Lower cell gates, pulse high |
| rect_lower_gate_off | output | 4 | Lower cell gates, pulse low |
| pwm_cell | output | 1 | Pulsed cell, 0 = upper, 1 = lower |
| pwm_duty | output | FRAC_W | Duty fraction for the pulsed cell |
| no_safe_fault | output | 1 | No safe realization this period |

## Verification
The stimuli pair references below and above 1.0, of both signs, with link-voltage orderings and current signs that flip the balancing choice. This separates the charging rule from its reversed form. The load-side code pairs are chosen so that the first-choice zero is safe in some cases and only the bottom-pair fallback is safe in others. This shows the search order at both of its levels. One case has no safe candidate at all, which exercises the fault path. References at exactly 1.0, just below 1.0 and above 2.0 test the level split and the duty saturation. Swapping the sign source with conflicting current and voltage signs shows which sign actually drives the choice.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    PR_ZTOP = 2'd0,
    PR_POS  = 2'd1,
    PR_NEG  = 2'd2,
    PR_ZBOT = 2'd3
  } pair_e;

  localparam int N_GROUPS = 14;

  // Bit k-1 of a mask is interconnect switch k.
  // First ten entries: capacitor shorts and opposition; last four: leg pairs.
  localparam logic [7:0] BAD_MASK [N_GROUPS] = '{
    8'h39, 8'hC9, 8'h36, 8'hC6, 8'h9C,
    8'h93, 8'h63, 8'h6C, 8'h69, 8'h96,
    8'h05, 8'h0A, 8'h50, 8'hA0
  };

  function automatic logic [3:0] pair_gates(pair_e p);
    logic [3:0] g;
    case (p)
      PR_ZTOP: g = 4'b0011;
      PR_POS:  g = 4'b1001;
      PR_NEG:  g = 4'b0110;
      default: g = 4'b1100;
    endcase
    return g;
  endfunction

  function automatic logic [7:0] link_vec(logic [3:0] up, logic [3:0] lo,
                                          logic [3:0] iu, logic [3:0] il);
    logic [7:0] v;
    v[0] = up[1];
    v[2] = up[3];
    v[1] = lo[0];
    v[3] = lo[2];
    v[4] = iu[1];
    v[6] = iu[3];
    v[5] = il[0];
    v[7] = il[2];
    return v;
  endfunction
endpackage

// File: rtl/hb_mode_sel.sv
module hb_mode_sel
  import hb_pkg::*;
#(
  parameter int REF_W  = 12,
  parameter int FRAC_W = 8,
  parameter int VDC_W  = 12
) (
  input  logic [REF_W-1:0]  ref_lvl,
  input  logic              cur_pos,
  input  logic              volt_pos,
  input  logic              sign_from_volt,
  input  logic [VDC_W-1:0]  vdc_upper,
  input  logic [VDC_W-1:0]  vdc_lower,
  output logic              pwm_is_lower,
  output logic              const_zero,
  output pair_e             act_code,
  output logic [FRAC_W-1:0] duty
);
  localparam int MW = REF_W + 1;
  localparam logic [MW-1:0] ONE = MW'(1) << FRAC_W;
  localparam logic [MW-1:0] DUTY_MAX = ONE - MW'(1);

  logic          neg, hi, charge, weak_is_lower, i_sign;
  logic [MW-1:0] mag, excess;

  always_comb begin
    neg    = ref_lvl[REF_W-1];
    mag    = neg ? (MW'(0) - {1'b1, ref_lvl}) : {1'b0, ref_lvl};
    hi     = (mag >= ONE);
    excess = mag - ONE;
    i_sign = sign_from_volt ? volt_pos : cur_pos;
    charge = (!neg) == i_sign;
    weak_is_lower = (vdc_upper > vdc_lower);
    if (hi) pwm_is_lower = charge ? !weak_is_lower : weak_is_lower;
    else    pwm_is_lower = charge ? weak_is_lower : !weak_is_lower;
    const_zero = !hi;
    act_code   = neg ? PR_NEG : PR_POS;
    if (!hi)                  duty = mag[FRAC_W-1:0];
    else if (excess > DUTY_MAX) duty = DUTY_MAX[FRAC_W-1:0];
    else                      duty = excess[FRAC_W-1:0];
  end
endmodule

// File: rtl/hb_safe_chk.sv
module hb_safe_chk
  import hb_pkg::*;
(
  input  pair_e up_code,
  input  pair_e lo_code,
  input  pair_e inv_up_code,
  input  pair_e inv_lo_code,
  output logic  safe
);
  logic [7:0]          vec;
  logic [N_GROUPS-1:0] hit;

  assign vec = link_vec(pair_gates(up_code), pair_gates(lo_code),
                        pair_gates(inv_up_code), pair_gates(inv_lo_code));

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    assign hit[g] = ((vec & BAD_MASK[g]) == BAD_MASK[g]);
  end

  assign safe = ~|hit;
endmodule

// File: rtl/hb_realize.sv
module hb_realize
  import hb_pkg::*;
(
  input  logic  pwm_is_lower,
  input  logic  const_zero,
  input  pair_e act_code,
  input  pair_e inv_up_code,
  input  pair_e inv_lo_code,
  output pair_e up_on,
  output pair_e up_off,
  output pair_e lo_on,
  output pair_e lo_off,
  output logic  found
);
  localparam int N_CAND = 4;

  pair_e c_up_on [N_CAND];
  pair_e c_up_off[N_CAND];
  pair_e c_lo_on [N_CAND];
  pair_e c_lo_off[N_CAND];
  logic  ok_on [N_CAND];
  logic  ok_off[N_CAND];

  for (genvar j = 0; j < N_CAND; j++) begin : g_cand
    pair_e fix_code, zero_code;
    assign fix_code  = const_zero ? ((j >= 2) ? PR_ZBOT : PR_ZTOP) : act_code;
    assign zero_code = ((j % 2) == 1) ? PR_ZBOT : PR_ZTOP;
    assign c_up_on[j]  = pwm_is_lower ? fix_code : act_code;
    assign c_up_off[j] = pwm_is_lower ? fix_code : zero_code;
    assign c_lo_on[j]  = pwm_is_lower ? act_code : fix_code;
    assign c_lo_off[j] = pwm_is_lower ? zero_code : fix_code;

    hb_safe_chk u_chk_on (
      .up_code(c_up_on[j]), .lo_code(c_lo_on[j]),
      .inv_up_code(inv_up_code), .inv_lo_code(inv_lo_code), .safe(ok_on[j]));
    hb_safe_chk u_chk_off (
      .up_code(c_up_off[j]), .lo_code(c_lo_off[j]),
      .inv_up_code(inv_up_code), .inv_lo_code(inv_lo_code), .safe(ok_off[j]));
  end

  always_comb begin
    found  = 1'b0;
    up_on  = PR_ZTOP;
    up_off = PR_ZTOP;
    lo_on  = PR_ZTOP;
    lo_off = PR_ZTOP;
    for (int j = N_CAND - 1; j >= 0; j--) begin
      if (ok_on[j] && ok_off[j]) begin
        found  = 1'b1;
        up_on  = c_up_on[j];
        up_off = c_up_off[j];
        lo_on  = c_lo_on[j];
        lo_off = c_lo_off[j];
      end
    end
  end
endmodule

// File: rtl/hb_cell_mode_assigner.sv
module hb_cell_mode_assigner
  import hb_pkg::*;
#(
  parameter int REF_W  = 12,
  parameter int FRAC_W = 8,
  parameter int VDC_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              period_strobe,
  input  logic [REF_W-1:0]  ref_lvl,
  input  logic              cur_pos,
  input  logic              volt_pos,
  input  logic              sign_from_volt,
  input  logic [VDC_W-1:0]  vdc_upper,
  input  logic [VDC_W-1:0]  vdc_lower,
  input  logic [1:0]        inv_upper_code,
  input  logic [1:0]        inv_lower_code,
  output logic [3:0]        rect_upper_gate_on,
  output logic [3:0]        rect_upper_gate_off,
  output logic [3:0]        rect_lower_gate_on,
  output logic [3:0]        rect_lower_gate_off,
  output logic              pwm_cell,
  output logic [FRAC_W-1:0] pwm_duty,
  output logic              no_safe_fault
);
  logic              sel_lower, sel_czero, found;
  pair_e             sel_act, r_up_on, r_up_off, r_lo_on, r_lo_off;
  logic [FRAC_W-1:0] sel_duty;
  pair_e             inv_up, inv_lo;
  pair_e             inv_up_q, inv_lo_q;

  assign inv_up = pair_e'(inv_upper_code);
  assign inv_lo = pair_e'(inv_lower_code);

  hb_mode_sel #(.REF_W(REF_W), .FRAC_W(FRAC_W), .VDC_W(VDC_W)) u_mode (
    .ref_lvl(ref_lvl), .cur_pos(cur_pos), .volt_pos(volt_pos),
    .sign_from_volt(sign_from_volt), .vdc_upper(vdc_upper),
    .vdc_lower(vdc_lower), .pwm_is_lower(sel_lower), .const_zero(sel_czero),
    .act_code(sel_act), .duty(sel_duty));

  hb_realize u_real (
    .pwm_is_lower(sel_lower), .const_zero(sel_czero), .act_code(sel_act),
    .inv_up_code(inv_up), .inv_lo_code(inv_lo),
    .up_on(r_up_on), .up_off(r_up_off), .lo_on(r_lo_on), .lo_off(r_lo_off),
    .found(found));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rect_upper_gate_on  <= '0;
      rect_upper_gate_off <= '0;
      rect_lower_gate_on  <= '0;
      rect_lower_gate_off <= '0;
      pwm_cell            <= 1'b0;
      pwm_duty            <= '0;
      no_safe_fault       <= 1'b0;
      inv_up_q            <= PR_ZTOP;
      inv_lo_q            <= PR_ZTOP;
    end else if (period_strobe) begin
      inv_up_q      <= inv_up;
      inv_lo_q      <= inv_lo;
      pwm_cell      <= sel_lower;
      pwm_duty      <= sel_duty;
      no_safe_fault <= !found;
      if (found) begin
        rect_upper_gate_on  <= pair_gates(r_up_on);
        rect_upper_gate_off <= pair_gates(r_up_off);
        rect_lower_gate_on  <= pair_gates(r_lo_on);
        rect_lower_gate_off <= pair_gates(r_lo_off);
      end else begin
        rect_upper_gate_on  <= '0;
        rect_upper_gate_off <= '0;
        rect_lower_gate_on  <= '0;
        rect_lower_gate_off <= '0;
      end
    end
  end

  // Checks on the registered outputs against the latched load-side codes
  logic [7:0] chk_vec_on, chk_vec_off;
  logic       bad_on, bad_off;
  always_comb begin
    chk_vec_on  = link_vec(rect_upper_gate_on, rect_lower_gate_on,
                           pair_gates(inv_up_q), pair_gates(inv_lo_q));
    chk_vec_off = link_vec(rect_upper_gate_off, rect_lower_gate_off,
                           pair_gates(inv_up_q), pair_gates(inv_lo_q));
    bad_on  = 1'b0;
    bad_off = 1'b0;
    for (int g = 0; g < N_GROUPS; g++) begin
      if ((chk_vec_on & BAD_MASK[g]) == BAD_MASK[g])   bad_on  = 1'b1;
      if ((chk_vec_off & BAD_MASK[g]) == BAD_MASK[g])  bad_off = 1'b1;
    end
  end

  assert_no_short_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !no_safe_fault |-> (!bad_on && !bad_off));

  assert_fault_gates_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    no_safe_fault |-> ({rect_upper_gate_on, rect_upper_gate_off,
                        rect_lower_gate_on, rect_lower_gate_off} == 16'h0));

  assert_hold_between_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !period_strobe |=> $stable({rect_upper_gate_on, rect_upper_gate_off,
                                rect_lower_gate_on, rect_lower_gate_off,
                                pwm_cell, pwm_duty, no_safe_fault}));

  assert_fixed_cell_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !no_safe_fault |-> (pwm_cell ? (rect_upper_gate_on == rect_upper_gate_off)
                                 : (rect_lower_gate_on == rect_lower_gate_off)));

  assert_one_pulsed_cell_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!no_safe_fault && rect_upper_gate_on != 4'h0) |->
      (pwm_cell ? (rect_lower_gate_on != rect_lower_gate_off)
                : (rect_upper_gate_on != rect_upper_gate_off)));
endmodule

// File: tb/hb_cell_mode_assigner_tb_top.sv
module hb_cell_mode_assigner_tb_top;
  localparam int REF_W = 12, FRAC_W = 8, VDC_W = 12;
  localparam logic [3:0] G_ZT = 4'b0011, G_P = 4'b1001, G_N = 4'b0110, G_ZB = 4'b1100;

  logic clk = 1'b0, rst_n = 1'b0, period_strobe = 1'b0;
  logic [REF_W-1:0] ref_lvl = '0;
  logic cur_pos = 1'b1, volt_pos = 1'b1, sign_from_volt = 1'b0;
  logic [VDC_W-1:0] vdc_upper = '0, vdc_lower = '0;
  logic [1:0] inv_upper_code = 2'd0, inv_lower_code = 2'd0;
  logic [3:0] uon, uoff, lon, loff;
  logic pwm_cell, no_safe_fault;
  logic [FRAC_W-1:0] pwm_duty;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hb_cell_mode_assigner #(.REF_W(REF_W), .FRAC_W(FRAC_W), .VDC_W(VDC_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .period_strobe(period_strobe), .ref_lvl(ref_lvl),
    .cur_pos(cur_pos), .volt_pos(volt_pos), .sign_from_volt(sign_from_volt),
    .vdc_upper(vdc_upper), .vdc_lower(vdc_lower),
    .inv_upper_code(inv_upper_code), .inv_lower_code(inv_lower_code),
    .rect_upper_gate_on(uon), .rect_upper_gate_off(uoff),
    .rect_lower_gate_on(lon), .rect_lower_gate_off(loff),
    .pwm_cell(pwm_cell), .pwm_duty(pwm_duty), .no_safe_fault(no_safe_fault));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_all(string tag, logic [3:0] e_uon, logic [3:0] e_uoff,
                            logic [3:0] e_lon, logic [3:0] e_loff, logic e_pwm,
                            logic [FRAC_W-1:0] e_duty, logic e_flt);
    chk({tag, " upper_on"}, 32'(uon), 32'(e_uon));
    chk({tag, " upper_off"}, 32'(uoff), 32'(e_uoff));
    chk({tag, " lower_on"}, 32'(lon), 32'(e_lon));
    chk({tag, " lower_off"}, 32'(loff), 32'(e_loff));
    chk({tag, " pwm_cell"}, 32'(pwm_cell), 32'(e_pwm));
    chk({tag, " duty"}, 32'(pwm_duty), 32'(e_duty));
    chk({tag, " fault"}, 32'(no_safe_fault), 32'(e_flt));
  endtask

  // Drive at a falling edge, strobe for one cycle, sample at the next falling edge.
  task automatic apply(int r, logic ip, logic vp, logic sv, int vu, int vl,
                       logic [1:0] iu, logic [1:0] il);
    @(negedge clk);
    ref_lvl = REF_W'(r); cur_pos = ip; volt_pos = vp; sign_from_volt = sv;
    vdc_upper = VDC_W'(vu); vdc_lower = VDC_W'(vl);
    inv_upper_code = iu; inv_lower_code = il;
    period_strobe = 1'b1;
    @(negedge clk);
    period_strobe = 1'b0;
  endtask

  task automatic t_reset;
    expect_all("R1 reset", 4'h0, 4'h0, 4'h0, 4'h0, 1'b0, '0, 1'b0);
  endtask

  task automatic t_low_first_choice;
    apply(128, 1, 1, 0, 700, 600, 2'd1, 2'd3);
    expect_all("R3 R4 low ref lower pulsed", G_ZT, G_ZT, G_P, G_ZT, 1'b1, 8'd128, 1'b0);
  endtask

  task automatic t_low_fallback;
    apply(128, 1, 1, 0, 600, 600, 2'd0, 2'd0);
    expect_all("R8 bottom-pair fallback", G_P, G_ZB, G_ZB, G_ZB, 1'b0, 8'd128, 1'b0);
  endtask

  task automatic t_no_safe;
    apply(384, 1, 1, 0, 500, 600, 2'd0, 2'd0);
    expect_all("R9 no safe candidate", 4'h0, 4'h0, 4'h0, 4'h0, 1'b1, 8'd128, 1'b1);
    apply(128, 1, 1, 0, 700, 600, 2'd1, 2'd3);
    expect_all("R9 fault clears", G_ZT, G_ZT, G_P, G_ZT, 1'b1, 8'd128, 1'b0);
  endtask

  task automatic t_negative_balance;
    apply(-384, 0, 0, 0, 600, 600, 2'd0, 2'd2);
    expect_all("R4 neg charging", G_N, G_N, G_N, G_ZB, 1'b1, 8'd128, 1'b0);
    apply(-384, 1, 0, 0, 600, 600, 2'd0, 2'd2);
    expect_all("R4 neg discharging", G_N, G_ZT, G_N, G_N, 1'b0, 8'd128, 1'b0);
  endtask

  task automatic t_sign_source;
    apply(-384, 0, 1, 1, 600, 600, 2'd0, 2'd2);
    expect_all("R5 voltage sign used", G_N, G_ZT, G_N, G_N, 1'b0, 8'd128, 1'b0);
    apply(-384, 0, 1, 0, 600, 600, 2'd0, 2'd2);
    expect_all("R5 current sign used", G_N, G_N, G_N, G_ZB, 1'b1, 8'd128, 1'b0);
  endtask

  task automatic t_level_bounds;
    apply(256, 1, 1, 0, 500, 600, 2'd1, 2'd0);
    expect_all("R3 R10 exactly one", G_P, G_P, G_P, G_ZT, 1'b1, 8'd0, 1'b0);
    apply(255, 1, 1, 0, 500, 600, 2'd1, 2'd0);
    expect_all("R3 R8 just below one", G_P, G_ZB, G_ZT, G_ZT, 1'b0, 8'd255, 1'b0);
    apply(640, 1, 1, 0, 500, 600, 2'd1, 2'd0);
    expect_all("R10 duty saturates", G_P, G_P, G_P, G_ZT, 1'b1, 8'd255, 1'b0);
  endtask

  task automatic t_hold;
    @(negedge clk);
    ref_lvl = REF_W'(-384); cur_pos = 1'b0; vdc_upper = 12'd900;
    inv_upper_code = 2'd0; inv_lower_code = 2'd0;
    repeat (3) @(negedge clk);
    expect_all("R2 hold without strobe", G_P, G_P, G_P, G_ZT, 1'b1, 8'd255, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_low_first_choice();
    t_low_fallback();
    t_no_safe();
    t_negative_balance();
    t_sign_source();
    t_level_bounds();
    t_hold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule